// File: doc/BRIEF.md
# Prescaled Timer Chain with Overflow and Periodic Interrupts

The block is a free-running time base for a small controller. The bus clock passes through a divide-by-four prescaler, which advances an 8-bit up counter. Software can read that counter at any moment. Each time the counter rolls over from 255 to 0, a timer-overflow flag is raised, which happens once every 1024 bus clocks. The same rollover also advances a 7-bit extension counter. The upper four stages of the extension counter act as taps for a periodic interrupt, and software picks one tap with a 2-bit rate field.

Two registers sit on a plain single-cycle register bus. The control/status register holds both flags, both interrupt enables and the rate field. The counter register is read-only. A single level interrupt output combines the two enabled flags. A one-cycle `rti_tick` pulse lets other logic follow the periodic event. The chain runs whenever reset is released and has no input that can stop it, so it keeps counting while the processor waits. The block has no internal states beyond its counters and flags, and it has no state transitions other than counting, flag setting and flag clearing.

Top module: `mft_timer`

## Requirements
- R1: The counter register at address 0x09 increases by one every four bus clocks and rolls over from 255 to 0.
- R2: Reset is active-low and asynchronous. It clears the prescaler, both counters, both flags and all control bits. After `rst_n` rises, the counter reads floor(k/4) mod 256, where k is the number of clock edges since release.
- R3: The overflow flag (bit 7 of the control/status register at 0x08) is set on the edge at which the counter rolls over. That edge is every 1024th edge after release.
- R4: The periodic flag (bit 6) is set on a rollover edge when the extension counter's stages up to the selected tap are all ones. The resulting interval is 2^(14+S) bus clocks, where S is the rate field in bits 1:0 (0 to 3).
- R5: `rti_tick` is high for exactly the one cycle that follows the edge that sets the periodic flag.
- R6: The control/status register reads as {overflow flag, periodic flag, overflow enable, periodic enable, 0, 0, rate}. A write stores bit 5 as the overflow enable, bit 4 as the periodic enable and bits 1:0 as the rate. Written bits 7 and 6 have no effect.
- R7: Writing 1 to bit 3 clears the overflow flag, and writing 1 to bit 2 clears the periodic flag. Writing 0 to either bit leaves its flag unchanged.
- R8: If a flag's set event and its clear write fall on the same edge, the flag ends up set.
- R9: `irq` equals (overflow flag AND overflow enable) OR (periodic flag AND periodic enable).
- R10: Changing the rate field does not disturb the counters. The new rate applies from the next rollover edge.
- R11: Writes to the counter address, and writes to any unmapped address, are ignored. Unmapped addresses read as 0.
- R12: `rdata` follows `addr` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Combined interrupt request |
| rti_tick | output | 1 | One-cycle pulse after each periodic event |

## Verification
A flag being set by the chain and the same flag being cleared by a software write can fall on the same clock edge. The bench provokes this on purpose: in the cycle just before every 1024th edge, it issues a control/status write with both clear bits set, at random about half the time. It then reads the register back and expects the overflow flag to still be set. When the edge is also a periodic event, it expects the periodic flag to still be set as well. The expected counter, flags and tick are all derived from the number of edges since reset and from the rate field held before each edge.

// File: rtl/mft_pkg.sv
`timescale 1ns/1ps
package mft_pkg;

    typedef enum logic [1:0] {
        RATE_2E14 = 2'd0,
        RATE_2E15 = 2'd1,
        RATE_2E16 = 2'd2,
        RATE_2E17 = 2'd3
    } rate_sel_e;

    localparam int BIT_OVF_FLAG  = 7;
    localparam int BIT_PER_FLAG  = 6;
    localparam int BIT_OVF_EN    = 5;
    localparam int BIT_PER_EN    = 4;
    localparam int BIT_OVF_CLR   = 3;
    localparam int BIT_PER_CLR   = 2;

    typedef struct packed {
        logic      ovf_en;
        logic      per_en;
        rate_sel_e rate;
    } ctl_t;

endpackage

// File: rtl/mft_prescaler.sv
`timescale 1ns/1ps
module mft_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic step
);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // one step per full prescaler cycle
    assign step = &div_q;

endmodule

// File: rtl/mft_chain.sv
`timescale 1ns/1ps
module mft_chain #(
    parameter int CNT_W = 8,
    parameter int EXT_W = 7,
    parameter int TAP_N = 4,
    parameter int SEL_W = $clog2(TAP_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt,
    output logic             ov_evt,
    output logic             rt_evt
);

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] ext_q;
    logic [TAP_N-1:0] tap_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ext_q <= '0;
        end else begin
            if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (ov_evt) begin
                ext_q <= ext_q + 1'b1;
            end
        end
    end

    // tap g fires when extension stages 0..(EXT_W-TAP_N+g) are all ones
    generate
        for (genvar g = 0; g < TAP_N; g++) begin : g_tap
            assign tap_hit[g] = &ext_q[EXT_W-TAP_N+g:0];
        end
    endgenerate

    assign ov_evt = step & (&cnt_q);
    assign rt_evt = ov_evt & tap_hit[sel];
    assign cnt    = cnt_q;

endmodule

// File: rtl/mft_regs.sv
`timescale 1ns/1ps
module mft_regs
    import mft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_csr,
    input  logic [7:0] wdata,
    input  logic       ov_evt,
    input  logic       rt_evt,
    output logic       ovf_flag,
    output logic       per_flag,
    output ctl_t       ctl
);

    logic unused_wbits;
    assign unused_wbits = ^wdata[BIT_OVF_FLAG:BIT_PER_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            per_flag <= 1'b0;
            ctl      <= '0;
        end else begin
            // set has priority over a same-edge clear
            if (ov_evt) begin
                ovf_flag <= 1'b1;
            end else if (wr_csr && wdata[BIT_OVF_CLR]) begin
                ovf_flag <= 1'b0;
            end
            if (rt_evt) begin
                per_flag <= 1'b1;
            end else if (wr_csr && wdata[BIT_PER_CLR]) begin
                per_flag <= 1'b0;
            end
            if (wr_csr) begin
                ctl.ovf_en <= wdata[BIT_OVF_EN];
                ctl.per_en <= wdata[BIT_PER_EN];
                ctl.rate   <= rate_sel_e'(wdata[1:0]);
            end
        end
    end

endmodule

// File: rtl/mft_timer.sv
`timescale 1ns/1ps
module mft_timer
    import mft_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                PRE_W    = 2,
    parameter int                CNT_W    = 8,
    parameter int                EXT_W    = 7,
    parameter int                TAP_N    = 4,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h08,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq,
    output logic              rti_tick
);

    localparam int DATA_W = 8;
    localparam int SEL_W  = $clog2(TAP_N);

    logic             step;
    logic [CNT_W-1:0] cnt_val;
    logic             ov_evt;
    logic             rt_evt;
    logic             wr_csr;
    logic             ovf_flag;
    logic             per_flag;
    ctl_t             ctl;
    logic             tick_q;

    assign wr_csr = wr_en && (addr == CSR_ADDR);

    mft_prescaler #(.DIV_W(PRE_W)) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .step (step)
    );

    mft_chain #(
        .CNT_W(CNT_W),
        .EXT_W(EXT_W),
        .TAP_N(TAP_N),
        .SEL_W(SEL_W)
    ) i_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .sel   (SEL_W'(ctl.rate)),
        .cnt   (cnt_val),
        .ov_evt(ov_evt),
        .rt_evt(rt_evt)
    );

    mft_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_csr  (wr_csr),
        .wdata   (wdata),
        .ov_evt  (ov_evt),
        .rt_evt  (rt_evt),
        .ovf_flag(ovf_flag),
        .per_flag(per_flag),
        .ctl     (ctl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= rt_evt;
        end
    end

    always_comb begin
        if (addr == CSR_ADDR) begin
            rdata = {ovf_flag, per_flag, ctl.ovf_en, ctl.per_en, 2'b00, ctl.rate};
        end else if (addr == CNT_ADDR) begin
            rdata = DATA_W'(cnt_val);
        end else begin
            rdata = '0;
        end
    end

    assign irq      = (ovf_flag & ctl.ovf_en) | (per_flag & ctl.per_en);
    assign rti_tick = tick_q;

endmodule

// File: rtl/mft_timer_chk.sv
`timescale 1ns/1ps
module mft_timer_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                CNT_W    = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              clr_bit,
    input logic [CNT_W-1:0]  cnt,
    input logic              ovf_flag,
    input logic              per_flag,
    input logic [1:0]        sel,
    input logic              rti_tick
);

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_ovf_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cnt) == {CNT_W{1'b1}}) && (cnt == '0)) |-> ovf_flag);

    assert_tick_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rti_tick |-> ((cnt == '0) && ($past(cnt) == {CNT_W{1'b1}}) && per_flag));

    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rti_tick |=> !rti_tick);

    assert_rate_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |-> $past(wr_en && (addr == CSR_ADDR)));

    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(wr_en && (addr == CSR_ADDR) && clr_bit));

endmodule

bind mft_timer mft_timer_chk #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .CSR_ADDR(CSR_ADDR)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .clr_bit (wdata[3]),
    .cnt     (cnt_val),
    .ovf_flag(ovf_flag),
    .per_flag(per_flag),
    .sel     (ctl.rate),
    .rti_tick(rti_tick)
);

// File: tb/test_mft_timer.sv
`timescale 1ns/1ps
module test_mft_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       rti_tick;

    always #2 clk = ~clk;

    mft_timer i_mft_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq),
        .rti_tick(rti_tick)
    );

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    int unsigned n_coll = 0;
    bit          done = 1'b0;

    // reference state
    int unsigned k = 0;
    logic        m_tof, m_rtif, m_toie, m_rtie, m_tick;
    logic [1:0]  m_sel;
    string       cyc_tag;
    bit          sel_moved;

    function automatic logic [7:0] exp_cnt(input int unsigned edges);
        return 8'((edges / 4) % 256);
    endfunction

    function automatic logic [7:0] exp_csr();
        return {m_tof, m_rtif, m_toie, m_rtie, 2'b00, m_sel};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h08) return exp_csr();
        if (a == 8'h09) return exp_cnt(k);
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %02h expected %02h (edge %0d)", tag, act, exp, k);
        end
    endtask

    task automatic model_clear();
        k = 0;
        m_tof = 0; m_rtif = 0; m_toie = 0; m_rtie = 0; m_tick = 0; m_sel = 2'd0;
    endtask

    task automatic model_edge(input bit w, input logic [7:0] a, input logic [7:0] d);
        bit ov, rt, wcsr;
        k++;
        ov   = (k % 1024) == 0;
        rt   = ov && ((k % (32'd1 << (14 + m_sel))) == 0);
        wcsr = w && (a == 8'h08);
        cyc_tag = "R6";
        if (wcsr && (d[3] || d[2])) cyc_tag = "R7";
        if (ov) cyc_tag = "R3";
        if (rt) cyc_tag = "R4";
        if (ov && wcsr && d[3]) begin
            cyc_tag = "R8";
            n_coll++;
        end
        if (ov) m_tof = 1'b1;
        else if (wcsr && d[3]) m_tof = 1'b0;
        if (rt) m_rtif = 1'b1;
        else if (wcsr && d[2]) m_rtif = 1'b0;
        if (wcsr) begin
            if (d[1:0] != m_sel) sel_moved = 1'b1;
            m_toie = d[5];
            m_rtie = d[4];
            m_sel  = d[1:0];
        end
        m_tick = rt;
    endtask

    task automatic check_outputs(input bit w, input logic [7:0] a);
        string t;
        if (a == 8'h08) t = cyc_tag;
        else if (a == 8'h09) begin
            t = w ? "R11" : (sel_moved ? "R10" : "R1");
            sel_moved = 1'b0;
        end else t = "R11";
        check(t, rdata, exp_rd(a));
        check("R9", {7'd0, irq}, {7'd0, (m_tof & m_toie) | (m_rtif & m_rtie)});
        check("R5", {7'd0, rti_tick}, {7'd0, m_tick});
    endtask

    // one bus cycle: drive at negedge, model at posedge, check at next negedge
    task automatic run_cycle(input bit w, input logic [7:0] a, input logic [7:0] d);
        wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        model_edge(w, a, d);
        @(negedge clk);
        check_outputs(w, a);
    endtask

    function automatic logic [1:0] pick_rate(input int unsigned nxt, input logic [1:0] r);
        if (nxt < 20000) return 2'd0;
        if (nxt < 40000) return 2'd1;
        if (nxt >= 70000 && nxt <= 131072) return 2'd3;
        return r;
    endfunction

    task automatic random_cycle();
        int unsigned r, nxt;
        logic [7:0] d, a;
        nxt = k + 1;
        r = $urandom % 100;
        d = 8'($urandom);
        a = 8'($urandom);
        if ((nxt % 1024) == 0 && ($urandom % 2) == 1) begin
            d[3] = 1'b1; d[2] = 1'b1;
            d[1:0] = pick_rate(nxt, d[1:0]);
            run_cycle(1'b1, 8'h08, d);
        end else if (r < 3) begin
            d[1:0] = pick_rate(nxt, d[1:0]);
            run_cycle(1'b1, 8'h08, d);
        end else if (r < 5) begin
            run_cycle(1'b1, 8'h09, d);
        end else if (r < 6) begin
            if (a == 8'h08 || a == 8'h09) a = 8'h3c;
            run_cycle(1'b1, a, d);
        end else if (r < 50) begin
            run_cycle(1'b0, 8'h09, d);
        end else if (r < 95) begin
            run_cycle(1'b0, 8'h08, d);
        end else begin
            run_cycle(1'b0, a, d);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        sel_moved = 1'b0;
        cyc_tag = "R6";
        repeat (2) @(negedge clk);
        // R2: reset state
        addr = 8'h09; #1 check("R2", rdata, 8'h00);
        addr = 8'h08; #1 check("R2", rdata, 8'h00);
        check("R2", {7'd0, irq}, 8'h00);
        check("R2", {7'd0, rti_tick}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5000; i++) random_cycle();

        // R2: reset mid-run clears everything, restart from zero
        run_cycle(1'b1, 8'h08, 8'h33);
        rst_n = 1'b0;
        model_clear();
        #1;
        addr = 8'h09; #1 check("R2", rdata, 8'h00);
        addr = 8'h08; #1 check("R2", rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) run_cycle(1'b0, 8'h09, 8'h00);
        check("R2", rdata, 8'd3);

        for (int i = 0; i < 150000; i++) begin
            random_cycle();
            if (i == 777) begin
                // R12: read mux follows the address without a clock edge
                addr = 8'h08; #0.5 check("R12", rdata, exp_csr());
                addr = 8'h09; #0.5 check("R12", rdata, exp_cnt(k));
                addr = 8'h55; #0.5 check("R12", rdata, 8'h00);
            end
        end
        if (n_coll == 0) begin
            n_fail++;
            $display("FAIL R8 actual 0 collisions expected >0");
        end
        n_chk++;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule